// File: doc/BRIEF.md
# Three-Channel Audio Quiet Detector with Output-Stage Muting

This block watches signed audio samples on three channels that come out of a two-input, three-output mixer. For each channel it decides when the signal has stayed quiet for long enough to be muted automatically. A sample is quiet when its magnitude is below a programmable amplitude threshold. A channel mutes only after a programmable number of consecutive valid quiet samples. The first valid loud sample releases it.

Each channel runs a small state machine with three states. CH_IDLE means the channel is disabled. CH_LISTEN means it is counting quiet samples. CH_MUTED means it is auto-muted. The transitions are:
- any state to CH_IDLE when the channel's enable is low;
- CH_IDLE to CH_LISTEN when the enable is high;
- CH_LISTEN to itself while counting, with the count reset by a loud sample;
- CH_LISTEN to CH_MUTED when the quiet count reaches the interval;
- CH_MUTED to CH_LISTEN on a valid loud sample.

While a channel is muted, its output-stage control tells the power stage how to behave. One setting of a shared mode bit keeps 50% duty switching. The other stops switching altogether. When a channel is not muted, the control always reads normal. PWM generation is done elsewhere.

Top module: `amute_ctrl`

## Requirements
- R1: After reset every `mute_flag` bit is 0 and every `stage_ctl` field is 00.
- R2: A sample's level is its absolute value. The most negative code (0x8000 at 16 bits) saturates to 0x7FFF instead of wrapping. A sample is quiet when its level is strictly below the unsigned `cfg_level`.
- R3: A channel's `mute_flag` goes to 1 at the clock edge that accepts its Nth consecutive quiet valid sample, where N is `cfg_span`. A `cfg_span` of 0 acts as 1.
- R4: A valid sample whose level is equal to or above `cfg_level` resets that channel's quiet count to zero.
- R5: Cycles with `smp_valid` low neither advance nor reset a quiet count, and they leave `mute_flag` unchanged.
- R6: A muted channel releases (`mute_flag` goes to 0) at the edge that accepts its first valid loud sample. A new count then starts from zero.
- R7: When `ch_enable[i]` is low, channel i's flag clears and its count resets at the next edge. After the enable returns, the channel spends one cycle in CH_IDLE before it counts samples.
- R8: For channel i, `stage_ctl[2i+1:2i]` uses these codes: 00 normal, 01 hold 50% duty, 10 switching off. A muted channel shows 01 when `cfg_off_mode` is 0 and 10 when it is 1. A change of the mode bit shows in the same cycle.
- R9: A channel that is not muted shows 00, whatever `cfg_off_mode` is.
- R10: The channels run independently. Channel i takes its sample from `smp_data[16i+15:16i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| smp_valid | input | 1 | Sample strobe shared by all channels |
| smp_data | input | 48 | Three signed 16-bit samples, channel 0 in the low bits |
| cfg_level | input | 16 | Unsigned quiet threshold |
| cfg_span | input | 16 | Inspection interval in valid samples |
| ch_enable | input | 3 | Per-channel auto-mute enable |
| cfg_off_mode | input | 1 | 0: hold 50% duty when muted, 1: stop switching |
| mute_flag | output | 3 | Per-channel auto-mute status |
| stage_ctl | output | 6 | Per-channel output-stage code, 2 bits each |

## Verification
The bench drives a sample exactly equal to the threshold. A design that compared with less-or-equal would count it as quiet and would neither release nor reset the count. It feeds the most negative code against a threshold of 0x8000, which only a saturating magnitude passes as quiet. It also checks that negative values above the threshold count as loud. Gaps in the valid strobe are placed both mid-count and while muted, to catch a design that counts clock cycles instead of samples. A disable pulse in the middle of a count must leave the counter cleared. A zero interval must mute on the first quiet sample instead of never or on wrap-around.

// File: rtl/amute_pkg.sv
package amute_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'b00,
        CH_LISTEN = 2'b01,
        CH_MUTED  = 2'b10
    } ch_state_e;

    typedef enum logic [1:0] {
        DRV_NORMAL = 2'b00,
        DRV_HALF   = 2'b01,
        DRV_OFF    = 2'b10
    } drive_e;

endpackage

// File: rtl/amute_level.sv
module amute_level #(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] limit,
    output logic                quiet
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [SAMPLE_W-1:0] magnitude;

    // absolute value, saturating the one code that has no positive twin
    always_comb begin
        if (sample == MOST_NEG) begin
            magnitude = MOST_POS;
        end else if (sample[SAMPLE_W-1]) begin
            magnitude = (~sample) + 1'b1;
        end else begin
            magnitude = sample;
        end
    end

    assign quiet = (magnitude < limit);

endmodule

// File: rtl/amute_chan_fsm.sv
module amute_chan_fsm
    import amute_pkg::*;
#(
    parameter int SPAN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              valid,
    input  logic              quiet,
    input  logic [SPAN_W-1:0] span,
    input  logic              off_mode,
    output logic              muted,
    output logic [1:0]        drive
);
    localparam logic [SPAN_W-1:0] SPAN_ONE = {{(SPAN_W-1){1'b0}}, 1'b1};

    ch_state_e         state_q, state_d;
    logic [SPAN_W-1:0] cnt_q, cnt_d;
    logic [SPAN_W:0]   cnt_inc;
    logic [SPAN_W-1:0] span_eff;
    logic              reached;

    assign span_eff = (span == '0) ? SPAN_ONE : span;
    assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
    assign reached  = (cnt_inc >= {1'b0, span_eff});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            state_d = CH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    state_d = CH_LISTEN;
                    cnt_d   = '0;
                end
                CH_LISTEN: begin
                    if (valid) begin
                        if (!quiet) begin
                            cnt_d = '0;
                        end else if (reached) begin
                            state_d = CH_MUTED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_inc[SPAN_W-1:0];
                        end
                    end
                end
                CH_MUTED: begin
                    if (valid && !quiet) begin
                        state_d = CH_LISTEN;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        muted = 1'b0;
        drive = DRV_NORMAL;
        unique case (state_q)
            CH_MUTED: begin
                muted = 1'b1;
                drive = off_mode ? DRV_OFF : DRV_HALF;
            end
            CH_IDLE, CH_LISTEN: begin
                muted = 1'b0;
                drive = DRV_NORMAL;
            end
            default: begin
                muted = 1'b0;
                drive = DRV_NORMAL;
            end
        endcase
    end

endmodule

// File: rtl/amute_ctrl.sv
module amute_ctrl #(
    parameter int NUM_CH   = 3,
    parameter int SAMPLE_W = 16,
    parameter int SPAN_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]   smp_data,
    input  logic [SAMPLE_W-1:0]          cfg_level,
    input  logic [SPAN_W-1:0]            cfg_span,
    input  logic [NUM_CH-1:0]            ch_enable,
    input  logic                         cfg_off_mode,
    output logic [NUM_CH-1:0]            mute_flag,
    output logic [2*NUM_CH-1:0]          stage_ctl
);
    localparam int DRV_W = 2;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic quiet;
        logic [DRV_W-1:0] drive;

        amute_level #(
            .SAMPLE_W(SAMPLE_W)
        ) u_level (
            .sample(smp_data[ch*SAMPLE_W +: SAMPLE_W]),
            .limit (cfg_level),
            .quiet (quiet)
        );

        amute_chan_fsm #(
            .SPAN_W(SPAN_W)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (ch_enable[ch]),
            .valid   (smp_valid),
            .quiet   (quiet),
            .span    (cfg_span),
            .off_mode(cfg_off_mode),
            .muted   (mute_flag[ch]),
            .drive   (drive)
        );

        assign stage_ctl[ch*DRV_W +: DRV_W] = drive;
    end

endmodule

// File: rtl/amute_ctrl_chk.sv
module amute_ctrl_chk #(
    parameter int NUM_CH = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smp_valid,
    input logic [NUM_CH-1:0]    ch_enable,
    input logic                 cfg_off_mode,
    input logic [NUM_CH-1:0]    mute_flag,
    input logic [2*NUM_CH-1:0]  stage_ctl
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_enable[i] |=> !mute_flag[i]); // R7
        AST_MUTE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mute_flag[i]) |-> $past(smp_valid && ch_enable[i])); // R3
        AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(mute_flag[i]) |-> $past(!ch_enable[i] || smp_valid)); // R6
        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_enable[i] && !smp_valid) |=> $stable(mute_flag[i])); // R5
        AST_NORMAL_UNMUTED: assert property (@(posedge clk) disable iff (!rst_n)
            !mute_flag[i] |-> (stage_ctl[2*i +: 2] == 2'b00)); // R9
        AST_MUTED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            mute_flag[i] |-> (stage_ctl[2*i +: 2] == (cfg_off_mode ? 2'b10 : 2'b01))); // R8
    end
endmodule

bind amute_ctrl amute_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_amute_ctrl.sv
`timescale 1ns/1ps
module sim_amute_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [47:0] smp_data = '0;
    logic [15:0] cfg_level = 16'd100;
    logic [15:0] cfg_span = 16'd4;
    logic [2:0]  ch_enable = 3'b111;
    logic        cfg_off_mode = 1'b0;
    logic [2:0]  mute_flag;
    logic [5:0]  stage_ctl;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    amute_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_level(cfg_level), .cfg_span(cfg_span), .ch_enable(ch_enable),
        .cfg_off_mode(cfg_off_mode), .mute_flag(mute_flag), .stage_ctl(stage_ctl)
    );

    task automatic chk_flags(input logic [2:0] exp, input string tag);
        total++;
        if (mute_flag !== exp) begin
            bad++;
            $display("FAIL %s mute_flag actual=%b expected=%b", tag, mute_flag, exp);
        end
    endtask

    task automatic chk_stage(input logic [5:0] exp, input string tag);
        total++;
        if (stage_ctl !== exp) begin
            bad++;
            $display("FAIL %s stage_ctl actual=%b expected=%b", tag, stage_ctl, exp);
        end
    endtask

    task automatic push(input logic [15:0] s0, input logic [15:0] s1, input logic [15:0] s2);
        @(negedge clk);
        smp_data  = {s2, s1, s0};
        smp_valid = 1'b1;
        @(posedge clk);
        #1;
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        push(16'd32000, 16'd32000, 16'd32000);
        chk_flags(3'b000, "R6 clear");
    endtask

    task automatic t_reset();
        chk_flags(3'b000, "R1 reset flags");
        chk_stage(6'b000000, "R1 reset stage");
    endtask

    task automatic t_basic();
        push(16'd50, -16'sd50, 16'd99);
        push(16'd0, 16'd0, 16'd0);
        push(16'd1, 16'd1, 16'd1);
        chk_flags(3'b000, "R3 before interval");
        push(16'd0, 16'd0, 16'd0);
        chk_flags(3'b111, "R3 at interval");
        chk_stage(6'b010101, "R8 half duty");
        @(negedge clk);
        cfg_off_mode = 1'b1;
        #1;
        chk_stage(6'b101010, "R8 switching off");
        push(16'd100, 16'd0, 16'd0);
        chk_flags(3'b110, "R6 R4 equal level releases");
        chk_stage(6'b101000, "R9 unmuted normal");
        @(negedge clk);
        cfg_off_mode = 1'b0;
        clear_all();
    endtask

    task automatic t_count_reset();
        repeat (3) push(16'd10, 16'd10, 16'd10);
        push(-16'sd100, 16'd10, 16'd10);
        chk_flags(3'b110, "R4 loud resets ch0");
        repeat (3) push(16'd10, 16'd10, 16'd10);
        chk_flags(3'b110, "R4 count restarted");
        push(16'd10, 16'd10, 16'd10);
        chk_flags(3'b111, "R4 full recount");
        clear_all();
    endtask

    task automatic t_gaps();
        repeat (2) push(16'd3, 16'd3, 16'd3);
        idle(5);
        chk_flags(3'b000, "R5 gap does not count");
        repeat (2) push(16'd3, 16'd3, 16'd3);
        chk_flags(3'b111, "R5 gap does not reset");
        idle(5);
        chk_flags(3'b111, "R5 gap keeps mute");
        clear_all();
    endtask

    task automatic t_saturate();
        @(negedge clk);
        cfg_level = 16'h8000;
        cfg_span  = 16'd2;
        repeat (2) push(16'h8000, 16'h7FFF, 16'h8000);
        chk_flags(3'b111, "R2 most negative saturates");
        @(negedge clk);
        cfg_level = 16'd100;
        clear_all();
        repeat (2) push(-16'sd200, -16'sd99, 16'd200);
        chk_flags(3'b010, "R2 absolute value");
        clear_all();
    endtask

    task automatic t_indep();
        @(negedge clk);
        cfg_span = 16'd3;
        repeat (3) push(16'd0, 16'd5000, -16'sd3);
        chk_flags(3'b101, "R10 independent channels");
        chk_stage(6'b010001, "R10 per-channel stage");
        clear_all();
    endtask

    task automatic t_enable();
        @(negedge clk);
        cfg_span = 16'd4;
        repeat (3) push(16'd1, 16'd1, 16'd1);
        @(negedge clk);
        ch_enable = 3'b110;
        @(negedge clk);
        ch_enable = 3'b111;
        idle(1);
        push(16'd1, 16'd1, 16'd1);
        chk_flags(3'b110, "R7 disable resets count");
        @(negedge clk);
        ch_enable = 3'b101;
        @(posedge clk);
        #1;
        chk_flags(3'b100, "R7 disable clears mute");
        chk_stage(6'b010000, "R7 disabled stage normal");
        @(negedge clk);
        ch_enable = 3'b111;
        idle(2);
        repeat (3) push(16'd1, 16'd1, 16'd1);
        chk_flags(3'b101, "R7 counting after reenable");
        clear_all();
    endtask

    task automatic t_span0();
        @(negedge clk);
        cfg_span = 16'd0;
        push(16'd2, 16'd2, 16'd2);
        chk_flags(3'b111, "R3 zero interval acts as one");
        clear_all();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_basic();
        t_count_reset();
        t_gaps();
        t_saturate();
        t_indep();
        t_enable();
        t_span0();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule